// File: doc/BRIEF.md
# Serial Offset Register Loader

This block fills the two almost-empty / almost-full offset registers of a FIFO (called X and Y here) from a one-bit serial stream after reset. At the end of a reset, two mode pins are sampled. If both are high, serial programming is armed. The block then takes one bit per write-clock edge on which the active-low load strobe is asserted. It holds the FIFO's input-ready flag low until every offset bit has arrived.

The two registers form one continuous most-significant-bit-first stream. Y is loaded first and X second, so the first bit lands in the top bit of Y and the final bit lands in bit 0 of X. Each register is W bits wide, where W is the base-2 logarithm of the FIFO depth. The intended value range of each offset is 1 to DEPTH-4. The block does not enforce that range; the driver that shifts the values in is responsible for it.

If serial mode is not armed at reset, the loader does nothing. It releases the ready flag on the first clock after reset so that other logic can take over.

Top module: `serial_offset_loader`

## Requirements
- R1: While `rst` is high (synchronous, active high), `in_ready_o` is 0 and both `x_ofs_o` and `y_ofs_o` are 0 from the next clock edge on.
- R2: Serial mode is armed only when `ser_data_i` and `ser_load_n_i` are both 1 on the last rising clock edge that sees `rst` high. Any other pin pair leaves serial mode off.
- R3: In serial mode, each rising edge on which `ser_load_n_i` is 0 shifts in one bit from `ser_data_i`. An edge with `ser_load_n_i` at 1 leaves both offsets unchanged.
- R4: The concatenation {Y, X} of 2*W bits acts as a left-shifting register fed at bit 0 of X. After all bits arrive, the first bit sits in Y bit W-1 and the last bit sits in X bit 0.
- R5: Programming takes exactly 2*W bits. `in_ready_o` rises on the rising edge that follows the edge that took the 2*W-th bit.
- R6: In serial mode, `in_ready_o` stays 0 until all 2*W bits have been taken.
- R7: After the 2*W-th bit, further load strobes are ignored. X, Y and `in_ready_o` stay unchanged until the next reset.
- R8: With serial mode off, load strobes have no effect, both offsets stay 0, and `in_ready_o` rises on the first rising edge after reset is released.
- R9: A new reset clears the progress, so a second programming sequence fully replaces earlier values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous active-high reset; mode pins sampled while high |
| ser_data_i | input | 1 | Serial data bit; also a mode pin during reset |
| ser_load_n_i | input | 1 | Active-low load strobe; also a mode pin during reset |
| x_ofs_o | output | W | X offset register (loaded last) |
| y_ofs_o | output | W | Y offset register (loaded first) |
| in_ready_o | output | 1 | Input-ready flag to the write port |

## Verification
A wrong bit count moves the rising edge of `in_ready_o` earlier or later by whole cycles, so the flag is checked on the exact cycle where it must rise. A wrong shift direction or a misplaced stream boundary corrupts the partial {Y, X} value after the very first bit. The bench therefore compares the offsets after every strobe, and also after idle gaps of varying length. A mode latch that samples the wrong pins or the wrong edge shows up either as offsets that move in the off state or as a ready flag that rises one cycle after release when it should not.

// File: rtl/sol_pkg.sv
package sol_pkg;
  typedef enum logic {
    LM_EXTERNAL = 1'b0,
    LM_SERIAL   = 1'b1
  } load_mode_e;
endpackage

// File: rtl/sol_mode_latch.sv
module sol_mode_latch
  import sol_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_a_i,
  input  logic       pin_b_i,
  output load_mode_e mode_o
);
  load_mode_e mode_q;

  // While reset is high, keep re-sampling; the last reset edge wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= (pin_a_i && pin_b_i) ? LM_SERIAL : LM_EXTERNAL;
    end
  end

  assign mode_o = mode_q;

  // R2: the armed mode never changes outside reset
  a_r2_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));
endmodule

// File: rtl/sol_bit_counter.sv
module sol_bit_counter #(
  parameter int TOTAL = 18,
  localparam int CW   = $clog2(TOTAL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (step_i && (count_q != CW'(TOTAL))) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign count_o = count_q;
  assign full_o  = (count_q == CW'(TOTAL));

  // R7: terminal count is sticky until reset
  a_r7_hold_at_terminal: assert property (@(posedge clk) disable iff (rst)
    full_o |=> full_o && $stable(count_q));
  // R5: never exceeds the bit total
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(TOTAL));
endmodule

// File: rtl/sol_shift_reg.sv
module sol_shift_reg #(
  parameter int LEN = 18
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step_i,
  input  logic           bit_i,
  output logic [LEN-1:0] data_o
);
  logic [LEN-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (step_i) begin
      sr_q <= {sr_q[LEN-2:0], bit_i};
    end
  end

  assign data_o = sr_q;

  // R3: no step, no change
  a_r3_idle_no_shift: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(sr_q));
  // R4: a step moves the old contents one place up
  a_r4_shift_up: assert property (@(posedge clk) disable iff (rst)
    step_i |=> sr_q[LEN-1:1] == $past(sr_q[LEN-2:0]));
endmodule

// File: rtl/serial_offset_loader.sv
module serial_offset_loader
  import sol_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int W     = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_data_i,
  input  logic         ser_load_n_i,
  output logic [W-1:0] x_ofs_o,
  output logic [W-1:0] y_ofs_o,
  output logic         in_ready_o
);
  localparam int TOTAL = 2 * W;
  localparam int CW    = $clog2(TOTAL + 1);

  load_mode_e      mode;
  logic [CW-1:0]   bit_cnt;
  logic            cnt_full;
  logic            step;
  logic [TOTAL-1:0] stream;
  logic            ready_q;

  sol_mode_latch u_mode (
    .clk     (clk),
    .rst     (rst),
    .pin_a_i (ser_data_i),
    .pin_b_i (ser_load_n_i),
    .mode_o  (mode)
  );

  assign step = (mode == LM_SERIAL) && !ser_load_n_i && !cnt_full;

  sol_bit_counter #(.TOTAL(TOTAL)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .step_i  (step),
    .count_o (bit_cnt),
    .full_o  (cnt_full)
  );

  sol_shift_reg #(.LEN(TOTAL)) u_sr (
    .clk    (clk),
    .rst    (rst),
    .step_i (step),
    .bit_i  (ser_data_i),
    .data_o (stream)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
    end else if (mode == LM_SERIAL) begin
      ready_q <= cnt_full;
    end else begin
      ready_q <= 1'b1;
    end
  end

  assign y_ofs_o    = stream[TOTAL-1:W];
  assign x_ofs_o    = stream[W-1:0];
  assign in_ready_o = ready_q;

  // R1: reset clears the flag and offsets
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !in_ready_o && (x_ofs_o == '0) && (y_ofs_o == '0));
  // R6: flag held low while bits are outstanding
  a_r6_low_while_loading: assert property (@(posedge clk) disable iff (rst)
    (mode == LM_SERIAL) && !cnt_full |-> !in_ready_o);
  // R5: flag rises one edge after the final bit
  a_r5_ready_after_last: assert property (@(posedge clk) disable iff (rst)
    (mode == LM_SERIAL) && $rose(cnt_full) |=> in_ready_o);
  // R8: external mode leaves offsets untouched
  a_r8_external_idle: assert property (@(posedge clk) disable iff (rst)
    (mode == LM_EXTERNAL) |-> (bit_cnt == '0) && (stream == '0));
endmodule

// File: tb/test_serial_offset_loader.sv
module test_serial_offset_loader;
  localparam int DEPTH = 16;
  localparam int W     = 4;
  localparam int TOTAL = 2 * W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sd  = 1'b0;
  logic         sen = 1'b1;
  logic [W-1:0] x_ofs, y_ofs;
  logic         ready;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  serial_offset_loader #(.DEPTH(DEPTH), .W(W)) i_serial_offset_loader (
    .clk          (clk),
    .rst          (rst),
    .ser_data_i   (sd),
    .ser_load_n_i (sen),
    .x_ofs_o      (x_ofs),
    .y_ofs_o      (y_ofs),
    .in_ready_o   (ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reset for two edges with the given mode pins, release at a negedge.
  task automatic do_reset(input logic a, input logic b);
    @(negedge clk);
    rst = 1'b1; sd = a; sen = b;
    @(negedge clk);
    chk("R1 ready in reset", ready, 0);
    chk("R1 offsets in reset", {y_ofs, x_ofs}, 0);
    @(negedge clk);
    rst = 1'b0; sen = 1'b1; sd = 1'b0;
  endtask

  // Drive one bit: strobe low for one edge.
  task automatic push(input logic b);
    sd = b; sen = 1'b0;
    @(negedge clk);
    sen = 1'b1;
  endtask

  initial begin
    // R8: mode pins other than 11 leave serial mode off
    for (int m = 0; m < 3; m++) begin
      do_reset(m[0], m[1]);
      chk("R8 ready before first edge", ready, 0);
      push(1'b1);
      chk("R8 ready after first edge", ready, 1);
      for (int k = 0; k < TOTAL + 2; k++) push(k[0]);
      chk("R2 R8 offsets untouched", {y_ofs, x_ofs}, 0);
      chk("R8 ready stays", ready, 1);
    end

    // Exhaustive sweep over every 2*W-bit stream (R3 R4 R5 R6 R7 R9)
    for (int p = 0; p < (1 << TOTAL); p++) begin
      logic [TOTAL-1:0] pat;
      pat = TOTAL'(p);
      do_reset(1'b1, 1'b1);
      for (int k = 0; k < TOTAL; k++) begin
        chk("R6 ready low while loading", ready, 0);
        push(pat[TOTAL-1-k]);
        chk("R4 partial stream", {y_ofs, x_ofs}, 32'(pat >> (TOTAL-1-k)));
        // idle gap of 0..2 cycles with strobe high
        for (int g = 0; g < (p + k) % 3; g++) begin
          @(negedge clk);
          chk("R3 idle strobe holds", {y_ofs, x_ofs}, 32'(pat >> (TOTAL-1-k)));
        end
      end
      if ((p + TOTAL - 1) % 3 == 0) begin
        chk("R5 ready not yet on last-bit edge", ready, 0);
        @(negedge clk);
      end
      chk("R5 ready after last bit", ready, 1);
      chk("R4 Y value", y_ofs, 32'(pat[TOTAL-1:W]));
      chk("R4 X value", x_ofs, 32'(pat[W-1:0]));
      if (p % 37 == 0) begin
        for (int k = 0; k < 3; k++) push(~pat[k]);
        chk("R7 extra bits ignored", {y_ofs, x_ofs}, 32'(pat));
        chk("R7 ready held", ready, 1);
      end
    end

    // R9: reprogram after a fresh reset replaces old contents
    do_reset(1'b1, 1'b1);
    chk("R9 cleared by reset", {y_ofs, x_ofs}, 0);
    for (int k = 0; k < TOTAL; k++) push(k[0]);
    @(negedge clk);
    chk("R9 new value", {y_ofs, x_ofs}, 32'h55);
    chk("R9 ready", ready, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule